// File: doc/BRIEF.md
# Memory-Mapped I/O Address Router

This block sits on the data side of a processor core. It takes one load or store at a time and decides where it goes. The destination is one of a small set of RAM regions, one slot on a narrow byte-wide peripheral bus, or nowhere at all. Region bounds, special byte addresses and the bus slot each address maps to are all fixed at elaboration.

Byte accesses are checked against a short table of special addresses before any region lookup. A hit sends the access to the bus slot named in the table. One slot is reserved for stopping the core: a byte store to its address raises a halt output that stays high until reset.

Accesses that miss everything still complete. Loads from such an address return zero, and stores to it are discarded. Region accesses take longer than peripheral accesses. The core sees this through a ready signal that stays low while an access is counting down its latency.

Top module: `mmio_route`

## Requirements
- R1: After reset, cpu_ready is 1, and cpu_rvalid, halt, ram_req and io_req are 0.
- R2: A word access to address A uses RAM region i when START[i] ≤ A < END[i]. It drives ram_sel = i and ram_addr = A − START[i], and a load returns ram_rdata.
- R3: When more than one region holds A, the region with the lowest index is used.
- R4: An access that matches no region and no table entry completes with no ram_req and no io_req pulse. A load returns 0.
- R5: A byte access whose address is in the special-address table goes to the bus. io_slot is the table's slot, io_we follows the access, and io_wdata is cpu_wdata[7:0]. A load returns {24'b0, io_rdata}. Default table: 0xFFFF0000 is slot 0 (keyboard input), 0xFFFF0004 is slot 1 (console output), 0xFFFF000C is slot 3 (stop).
- R6: A word access to a special-table address skips the table and is decoded as a memory address.
- R7: A byte store to the stop address sets halt from the completion edge onward, until reset. A byte load from that address goes to slot 3 and leaves halt at 0.
- R8: cpu_rvalid rises 3 clock edges after the accepting edge for a RAM access, and 1 edge after for a bus access or an unmatched access.
- R9: An access is accepted on an edge where cpu_valid and cpu_ready are both 1. cpu_ready is 0 from that edge until the response edge. cpu_valid and the request fields are ignored while cpu_ready is 0.
- R10: Words are big-endian. For a byte access with A[1:0] = k, only ram_be bit 3−k is set and the byte is copied to all four lanes of ram_wdata. A byte load returns ram_rdata bits [31−8k : 24−8k], zero-extended. A word access drives ram_be = 4'hF.
- R11: Every RAM or bus access produces exactly one single-cycle ram_req or io_req pulse, in the last cycle before cpu_rvalid. The two pulses never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 32 | Store data (byte in bits 7:0) |
| cpu_rvalid | output | 1 | Response strobe, one cycle |
| cpu_rdata | output | 32 | Load result (0 for stores) |
| ram_req | output | 1 | RAM strobe, last busy cycle |
| ram_we | output | 1 | RAM store |
| ram_sel | output | SEL_W | Selected region index |
| ram_addr | output | AW | Byte offset inside the region |
| ram_be | output | 4 | Byte enables, bit 3 = lowest address |
| ram_wdata | output | 32 | RAM store data |
| ram_rdata | input | 32 | RAM load data, sampled with ram_req |
| io_req | output | 1 | Bus strobe |
| io_we | output | 1 | Bus store |
| io_slot | output | SLOT_W | Bus slot number |
| io_wdata | output | 8 | Bus store byte |
| io_rdata | input | 8 | Bus load byte, sampled with io_req |
| halt | output | 1 | Stop request, sticky until reset |

## Verification
A wrong target or region choice shows on the first strobe of the access: the wrong one of ram_req or io_req pulses, or ram_sel or ram_addr carries the wrong value. A miscounted latency moves cpu_rvalid away from its fixed edge, or moves the strobe out of the cycle just before it. A wrong byte lane shows up at once in ram_be and in the zero-extended load data. A halt flag that is not held, or is set when it should not be, can be seen on the halt pin on the cycle after the stop-address access.

// File: rtl/mmio_route_pkg.sv
package mmio_route_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_IO   = 2'd2
    } tgt_e;

endpackage

// File: rtl/mmio_region_match.sv
module mmio_region_match #(
    parameter int AW    = 32,
    parameter int NREG  = 2,
    parameter int SEL_W = 1,
    parameter logic [NREG-1:0][AW-1:0] REG_START = '0,
    parameter logic [NREG-1:0][AW-1:0] REG_END   = '0
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [SEL_W-1:0] sel,
    output logic [AW-1:0]    offset
);

    logic [NREG-1:0] in_range;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_cmp
            assign in_range[g] = (addr >= REG_START[g]) && (addr < REG_END[g]);
        end
    endgenerate

    // Lowest index wins: scan from the top so lower indices overwrite.
    always_comb begin
        sel    = '0;
        offset = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (in_range[i]) begin
                sel    = SEL_W'(i);
                offset = addr - REG_START[i];
            end
        end
    end

    assign hit = |in_range;

endmodule

// File: rtl/mmio_port_match.sv
module mmio_port_match #(
    parameter int AW     = 32,
    parameter int NPORT  = 3,
    parameter int SLOT_W = 2,
    parameter logic [NPORT-1:0][AW-1:0]     PORT_ADDR = '0,
    parameter logic [NPORT-1:0][SLOT_W-1:0] PORT_SLOT = '0
) (
    input  logic [AW-1:0]     addr,
    output logic              hit,
    output logic [SLOT_W-1:0] slot
);

    logic [NPORT-1:0] eq;

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_eq
            assign eq[g] = (addr == PORT_ADDR[g]);
        end
    endgenerate

    always_comb begin
        slot = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (eq[i]) slot = PORT_SLOT[i];
        end
    end

    assign hit = |eq;

endmodule

// File: rtl/mmio_lane.sv
module mmio_lane
    import mmio_route_pkg::*;
(
    input  logic                  is_byte,
    input  logic [LANE_W-1:0]     lane,
    input  logic [WORD_W-1:0]     wdata_in,
    input  logic [WORD_W-1:0]     word_in,
    output logic [WORD_BYTES-1:0] be,
    output logic [WORD_W-1:0]     wdata_out,
    output logic [WORD_W-1:0]     rdata_out
);

    // Big-endian: lowest address is the most significant byte.
    generate
        for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
            localparam int BIT = WORD_BYTES - 1 - g;
            assign be[BIT] = !is_byte || (lane == LANE_W'(g));
            assign wdata_out[BIT*8 +: 8] = is_byte ? wdata_in[7:0]
                                                   : wdata_in[BIT*8 +: 8];
        end
    endgenerate

    logic [WORD_W-1:0] shifted;
    assign shifted   = word_in >> {~lane, 3'b000};
    assign rdata_out = is_byte ? {{(WORD_W-8){1'b0}}, shifted[7:0]} : word_in;

endmodule

// File: rtl/mmio_route.sv
module mmio_route
    import mmio_route_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NREG      = 2,
    parameter logic [NREG-1:0][AW-1:0] REG_START = {32'hAFFF_0000, 32'h8003_0000},
    parameter logic [NREG-1:0][AW-1:0] REG_END   = {32'hB000_0000, 32'h8004_0000},
    parameter int NPORT     = 3,
    parameter int SLOT_W    = 2,
    parameter logic [NPORT-1:0][AW-1:0]     PORT_ADDR = {32'hFFFF_000C, 32'hFFFF_0004, 32'hFFFF_0000},
    parameter logic [NPORT-1:0][SLOT_W-1:0] PORT_SLOT = {2'd3, 2'd1, 2'd0},
    parameter int HALT_SLOT = 3,
    parameter int RAM_LAT   = 3,
    parameter int IO_LAT    = 1,
    parameter int MISS_LAT  = 1,
    localparam int SEL_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_valid,
    output logic                  cpu_ready,
    input  logic                  cpu_we,
    input  logic                  cpu_byte,
    input  logic [AW-1:0]         cpu_addr,
    input  logic [WORD_W-1:0]     cpu_wdata,
    output logic                  cpu_rvalid,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  ram_req,
    output logic                  ram_we,
    output logic [SEL_W-1:0]      ram_sel,
    output logic [AW-1:0]         ram_addr,
    output logic [WORD_BYTES-1:0] ram_be,
    output logic [WORD_W-1:0]     ram_wdata,
    input  logic [WORD_W-1:0]     ram_rdata,
    output logic                  io_req,
    output logic                  io_we,
    output logic [SLOT_W-1:0]     io_slot,
    output logic [7:0]            io_wdata,
    input  logic [7:0]            io_rdata,
    output logic                  halt
);

    localparam int MAX_LAT_A = (RAM_LAT > IO_LAT) ? RAM_LAT : IO_LAT;
    localparam int MAX_LAT   = (MAX_LAT_A > MISS_LAT) ? MAX_LAT_A : MISS_LAT;
    localparam int CNT_W     = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic                busy;
        logic [CNT_W-1:0]    cnt;
        tgt_e                tgt;
        logic                we;
        logic                is_byte;
        logic [LANE_W-1:0]   lane;
        logic [WORD_W-1:0]   wdata;
        logic [SEL_W-1:0]    sel;
        logic [AW-1:0]       off;
        logic [SLOT_W-1:0]   slot;
        logic                rvalid;
        logic [WORD_W-1:0]   rdata;
        logic                halt;
    } state_t;

    state_t st_d, st_q;

    logic              reg_hit;
    logic [SEL_W-1:0]  reg_sel;
    logic [AW-1:0]     reg_off;
    logic              port_hit;
    logic [SLOT_W-1:0] port_slot;
    logic [WORD_W-1:0] lane_rdata;
    logic              accept_w;
    logic              last_w;

    mmio_region_match #(
        .AW(AW), .NREG(NREG), .SEL_W(SEL_W),
        .REG_START(REG_START), .REG_END(REG_END)
    ) i_region (
        .addr(cpu_addr), .hit(reg_hit), .sel(reg_sel), .offset(reg_off)
    );

    mmio_port_match #(
        .AW(AW), .NPORT(NPORT), .SLOT_W(SLOT_W),
        .PORT_ADDR(PORT_ADDR), .PORT_SLOT(PORT_SLOT)
    ) i_port (
        .addr(cpu_addr), .hit(port_hit), .slot(port_slot)
    );

    mmio_lane i_lane (
        .is_byte  (st_q.is_byte),
        .lane     (st_q.lane),
        .wdata_in (st_q.wdata),
        .word_in  (ram_rdata),
        .be       (ram_be),
        .wdata_out(ram_wdata),
        .rdata_out(lane_rdata)
    );

    assign accept_w = cpu_valid && !st_q.busy;
    assign last_w   = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (accept_w) begin
            st_d.busy    = 1'b1;
            st_d.we      = cpu_we;
            st_d.is_byte = cpu_byte;
            st_d.lane    = cpu_addr[LANE_W-1:0];
            st_d.wdata   = cpu_wdata;
            st_d.sel     = reg_sel;
            st_d.off     = reg_off;
            st_d.slot    = port_slot;
            if (cpu_byte && port_hit) begin
                st_d.tgt = TGT_IO;
                st_d.cnt = CNT_W'(IO_LAT - 1);
            end else if (reg_hit) begin
                st_d.tgt = TGT_RAM;
                st_d.cnt = CNT_W'(RAM_LAT - 1);
            end else begin
                st_d.tgt = TGT_NONE;
                st_d.cnt = CNT_W'(MISS_LAT - 1);
            end
        end else if (last_w) begin
            st_d.busy   = 1'b0;
            st_d.rvalid = 1'b1;
            st_d.rdata  = '0;
            if (!st_q.we) begin
                case (st_q.tgt)
                    TGT_RAM: st_d.rdata = lane_rdata;
                    TGT_IO:  st_d.rdata = {{(WORD_W-8){1'b0}}, io_rdata};
                    default: st_d.rdata = '0;
                endcase
            end
            if (st_q.tgt == TGT_IO && st_q.we && st_q.is_byte &&
                st_q.slot == SLOT_W'(HALT_SLOT)) begin
                st_d.halt = 1'b1;
            end
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_ready  = !st_q.busy;
    assign cpu_rvalid = st_q.rvalid;
    assign cpu_rdata  = st_q.rdata;
    assign ram_req    = last_w && (st_q.tgt == TGT_RAM);
    assign ram_we     = st_q.we;
    assign ram_sel    = st_q.sel;
    assign ram_addr   = st_q.off;
    assign io_req     = last_w && (st_q.tgt == TGT_IO);
    assign io_we      = st_q.we;
    assign io_slot    = st_q.slot;
    assign io_wdata   = st_q.wdata[7:0];
    assign halt       = st_q.halt;

endmodule

// File: rtl/mmio_route_chk.sv
module mmio_route_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_valid,
    input logic cpu_ready,
    input logic cpu_rvalid,
    input logic ram_req,
    input logic io_req,
    input logic halt
);

    // R9
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready) |=> !cpu_ready);

    // R9
    resp_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> cpu_ready);

    // R11
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_req && io_req));

    // R11
    strobe_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req || io_req) |=> cpu_rvalid);

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req || io_req) |-> !cpu_ready);

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

endmodule

bind mmio_route mmio_route_chk i_chk (.*);

// File: tb/test_mmio_route.sv
`timescale 1ns/100ps
module test_mmio_route;

    localparam logic [31:0] R0S = 32'h8003_0000, R0E = 32'h8004_0000;
    localparam logic [31:0] R1S = 32'h8003_F000, R1E = 32'h8010_0000;
    localparam logic [31:0] A_KBD = 32'hFFFF_0000, A_CON = 32'hFFFF_0004,
                            A_HLT = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        ram_req, ram_we;
    logic [0:0]  ram_sel;
    logic [31:0] ram_addr, ram_wdata, ram_rdata;
    logic [3:0]  ram_be;
    logic        io_req, io_we, halt;
    logic [1:0]  io_slot;
    logic [7:0]  io_wdata, io_rdata;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] ram_model(input logic s, input logic [31:0] off);
        return 32'hC0DE_0000 ^ off ^ (s ? 32'h0F00_0000 : 32'h0);
    endfunction

    assign ram_rdata = ram_model(ram_sel[0], ram_addr);
    assign io_rdata  = 8'h40 + {6'b0, io_slot};

    mmio_route #(
        .REG_START({R1S, R0S}), .REG_END({R1E, R0E}),
        .PORT_ADDR({A_HLT, A_CON, A_KBD})
    ) i_mmio_route (.*);

    int checks = 0, fails = 0;

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // results of the last access
    logic [31:0] rd_g, c_off, c_rwd;
    logic [7:0]  c_iwd;
    logic [3:0]  c_be;
    logic [1:0]  c_slot;
    logic        c_sel, c_rwe, c_iwe, busy_ok;
    int          lat_g, nram, nio, str_at;

    task automatic access(input logic we, input logic byt, input logic [31:0] a,
                          input logic [31:0] wd, input bit hold);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_byte = byt; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        if (hold) begin
            cpu_we = 1'b1; cpu_byte = 1'b1; cpu_addr = A_HLT; cpu_wdata = 32'hFF;
        end else cpu_valid = 1'b0;
        nram = 0; nio = 0; busy_ok = 1'b1; str_at = -1; lat_g = -1; rd_g = 'x;
        for (int n = 1; n <= 20; n++) begin
            if (n > 1) @(negedge clk);
            if (ram_req) begin
                nram++; str_at = n; c_sel = ram_sel[0]; c_off = ram_addr;
                c_be = ram_be; c_rwd = ram_wdata; c_rwe = ram_we;
            end
            if (io_req) begin
                nio++; str_at = n; c_slot = io_slot; c_iwd = io_wdata; c_iwe = io_we;
            end
            if (cpu_rvalid) begin
                lat_g = n - 1; rd_g = cpu_rdata; cpu_valid = 1'b0;
                break;
            end
            if (cpu_ready) busy_ok = 1'b0;
        end
    endtask

    typedef struct packed {
        logic        we;
        logic        byt;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [1:0]  kind;   // 0 unmatched, 1 RAM, 2 bus
        logic        sel;
        logic [1:0]  slot;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h8003_0000, 32'h0,         2'd1, 1'b0, 2'd0, 8'd2},  // R2 start
        '{1'b0, 1'b0, 32'h8003_EFFC, 32'h0,         2'd1, 1'b0, 2'd0, 8'd2},  // R2
        '{1'b0, 1'b0, 32'h8003_F000, 32'h0,         2'd1, 1'b0, 2'd0, 8'd3},  // R3 overlap
        '{1'b0, 1'b0, 32'h8003_FFFC, 32'h0,         2'd1, 1'b0, 2'd0, 8'd3},  // R3
        '{1'b0, 1'b0, 32'h8004_0000, 32'h0,         2'd1, 1'b1, 2'd0, 8'd2},  // R2 end of r0
        '{1'b0, 1'b0, 32'h800F_FFFC, 32'h0,         2'd1, 1'b1, 2'd0, 8'd2},  // R2
        '{1'b0, 1'b0, 32'h8010_0000, 32'h0,         2'd0, 1'b0, 2'd0, 8'd4},  // R4 end excl
        '{1'b0, 1'b0, 32'h8002_FFFC, 32'h0,         2'd0, 1'b0, 2'd0, 8'd4},  // R4
        '{1'b1, 1'b0, 32'h9000_0000, 32'hDEAD_BEEF, 2'd0, 1'b0, 2'd0, 8'd4},  // R4 drop
        '{1'b0, 1'b1, 32'h8003_0101, 32'h0,         2'd1, 1'b0, 2'd0, 8'd10}, // R10 lane1
        '{1'b0, 1'b1, 32'h8003_0203, 32'h0,         2'd1, 1'b0, 2'd0, 8'd10}, // R10 lane3
        '{1'b1, 1'b1, 32'h8005_0002, 32'h0000_00A5, 2'd1, 1'b1, 2'd0, 8'd10}, // R10
        '{1'b1, 1'b0, 32'h8003_0010, 32'h1122_3344, 2'd1, 1'b0, 2'd0, 8'd10}, // R10 word
        '{1'b1, 1'b1, 32'h8003_0000, 32'h0000_003C, 2'd1, 1'b0, 2'd0, 8'd10}, // R10 lane0
        '{1'b0, 1'b1, 32'hFFFF_0000, 32'h0,         2'd2, 1'b0, 2'd0, 8'd5},  // R5 keyboard
        '{1'b1, 1'b1, 32'hFFFF_0004, 32'h0000_005A, 2'd2, 1'b0, 2'd1, 8'd5},  // R5 console
        '{1'b0, 1'b1, 32'hFFFF_0004, 32'h0,         2'd2, 1'b0, 2'd1, 8'd5},  // R5
        '{1'b0, 1'b0, 32'hFFFF_0004, 32'h0,         2'd0, 1'b0, 2'd0, 8'd6},  // R6 word
        '{1'b1, 1'b1, 32'h9000_0001, 32'h0000_0077, 2'd0, 1'b0, 2'd0, 8'd4}   // R4 byte drop
    };

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(1, "ready in reset", {31'b0, cpu_ready}, 32'd1);
        chk(1, "rvalid in reset", {31'b0, cpu_rvalid}, 32'd0);
        chk(1, "halt in reset", {31'b0, halt}, 32'd0);
        chk(1, "strobes in reset", {30'b0, ram_req, io_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, "ready after reset", {31'b0, cpu_ready}, 32'd1);

        foreach (VECS[i]) begin
            vec_t v;
            logic [31:0] base, off, exp_rd, word;
            int req;
            v = VECS[i];
            req = int'(v.req);
            access(v.we, v.byt, v.addr, v.wd, 1'b0);
            base = v.sel ? R1S : R0S;
            off  = v.addr - base;
            word = ram_model(v.sel, off);
            exp_rd = '0;
            if (!v.we) begin
                if (v.kind == 2'd1)
                    exp_rd = v.byt ? {24'b0, word[8*(3-int'(v.addr[1:0])) +: 8]} : word;
                else if (v.kind == 2'd2)
                    exp_rd = {24'b0, 8'h40 + {6'b0, v.slot}};
            end
            chk(req, "load data", rd_g, exp_rd);
            chk(8, "latency (R8)", lat_g, (v.kind == 2'd1) ? 3 : 1);
            chk(req, "ram strobes", nram, (v.kind == 2'd1) ? 1 : 0);
            chk(req, "bus strobes", nio, (v.kind == 2'd2) ? 1 : 0);
            chk(9, "ready low while busy (R9)", {31'b0, busy_ok}, 32'd1);
            if (v.kind != 2'd0) chk(11, "strobe cycle (R11)", str_at, lat_g);
            if (v.kind == 2'd1) begin
                chk(req, "ram_sel", {31'b0, c_sel}, {31'b0, v.sel});
                chk(req, "ram_addr", c_off, off);
                chk(req, "ram_we", {31'b0, c_rwe}, {31'b0, v.we});
                chk(10, "ram_be (R10)", {28'b0, c_be},
                    v.byt ? (32'd8 >> v.addr[1:0]) : 32'hF);
                if (v.we)
                    chk(10, "ram_wdata (R10)", c_rwd, v.byt ? {4{v.wd[7:0]}} : v.wd);
            end
            if (v.kind == 2'd2) begin
                chk(5, "io_slot (R5)", {30'b0, c_slot}, {30'b0, v.slot});
                chk(5, "io_we (R5)", {31'b0, c_iwe}, {31'b0, v.we});
                if (v.we) chk(5, "io_wdata (R5)", {24'b0, c_iwd}, {24'b0, v.wd[7:0]});
            end
        end

        // R9: request fields changed and valid held while busy are ignored
        access(1'b0, 1'b0, 32'h8003_0040, 32'h0, 1'b1);
        chk(9, "held request ignored: ram strobes", nram, 1);
        chk(9, "held request ignored: bus strobes", nio, 0);
        chk(9, "held request ignored: ram_addr", c_off, 32'h40);
        chk(9, "held request ignored: data", rd_g, ram_model(1'b0, 32'h40));
        chk(9, "held request ignored: halt", {31'b0, halt}, 32'd0);

        // R7: load from stop address reaches slot 3 but does not halt
        access(1'b0, 1'b1, A_HLT, 32'h0, 1'b0);
        chk(7, "stop load slot", {30'b0, c_slot}, 32'd3);
        chk(7, "stop load data", rd_g, 32'h43);
        chk(7, "stop load halt", {31'b0, halt}, 32'd0);
        // R7: store to stop address raises halt
        access(1'b1, 1'b1, A_HLT, 32'h1, 1'b0);
        chk(7, "stop store slot", {30'b0, c_slot}, 32'd3);
        chk(7, "stop store halt", {31'b0, halt}, 32'd1);
        access(1'b0, 1'b0, 32'h8003_0000, 32'h0, 1'b0);
        chk(7, "halt sticky", {31'b0, halt}, 32'd1);
        // R1: reset clears halt
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(1, "halt cleared by reset", {31'b0, halt}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, "ready after second reset", {31'b0, cpu_ready}, 32'd1);

        summary();
        $finish;
    end

endmodule